// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block turns a stream of qualified bus writes, each an address and a data byte, into the operations of a NOR-flash-style command interface. Program and erase requests must be preceded by two unlock writes. The block keeps a single state register that tracks the current device mode: read-array, autoselect, program pending, erase pending, embedded operation busy, erase-suspended or error. It reports that mode on a three-bit output.

When a command completes its sequence, the block raises a one-cycle start pulse towards an external array controller. The pulse is accompanied by registered target address and data. The controller later reports completion or failure on two inputs. A read-address input is classified so that the read mux can choose between array data and status data. This matters most while an erase is suspended, because only reads inside the suspended sector must return status.

Any write that breaks a sequence sends the machine back to read-array mode. The reset byte F0h aborts an unfinished sequence or leaves autoselect and error mode. A program operation may run nested inside a suspended erase.

Top module: `flash_cmd_fsm`

## Requirements
- R1: After reset, or after rst_n is pulled low at any time, mode is 0 (read-array), all four start pulses are low and rd_status is 0.
- R2: The writes AAh@555h, 55h@2AAh and A0h@555h, followed by any fourth write, raise prog_start for exactly one cycle with prog_addr/prog_data equal to the fourth write. Mode is 2 (program pending) after the third write and 4 (busy) after the fourth. In each unlock compare only address bits [10:0] are examined.
- R3: A write whose address or data does not match the next expected unlock or command cycle returns mode to 0. A command byte written outside a sequence has no effect.
- R4: Data F0h at any address returns autoselect mode (1) to mode 0. Written during any cycle of an erase sequence (mode 3), it returns to mode 0 without any erase pulse.
- R5: The sequence AA@555, 55@2AA, 80@555, AA@555, 55@2AA followed by 30h at a sector address starts a sector erase. If the last write is instead 10h@555 it starts a chip erase. Mode is 3 from the 80h write until the last write. The last write raises erase_start for one cycle, latches erase_addr and sets erase_chip to 1 only for chip erase.
- R6: While mode is 4, writes have no effect on mode or pulses, with one exception: B0h during an erase.
- R7: B0h during a running erase gives one suspend_start pulse and mode 5. While suspended, 30h at any address gives one resume_start pulse and mode 4.
- R8: While suspended, AA@555, 55@2AA and A0@555 followed by a write start a nested program (prog_start, mode 4). Its op_done returns the block to mode 5.
- R9: op_done in mode 4 returns to mode 0, or to mode 5 for a nested program. op_error in mode 4 wins over op_done and gives mode 6. Mode 6 is left only by F0h. op_done and op_error have no effect outside mode 4.
- R10: rd_status is 1 in modes 4 and 6. While an erase is suspended (mode 5, or mode 2 of a nested program), rd_status is 1 only when rd_addr>>SECT_SHIFT equals erase_addr>>SECT_SHIFT, or for any address after a chip erase.
- R11: In the suspended mode, writes other than 30h or a correct unlock cycle leave mode at 5. This includes F0h.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| wr_valid | input | 1 | Qualified write event |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| op_done | input | 1 | Array controller finished the operation |
| op_error | input | 1 | Array controller reports failure |
| rd_addr | input | AW | Read address to classify |
| mode | output | 3 | Current mode code 0..6 |
| rd_status | output | 1 | Read should return status instead of array data |
| prog_start | output | 1 | One-cycle program start |
| prog_addr | output | AW | Program target address |
| prog_data | output | DW | Program data |
| erase_start | output | 1 | One-cycle erase start |
| erase_chip | output | 1 | Latched erase is chip-wide |
| erase_addr | output | AW | Latched erase sector address |
| suspend_start | output | 1 | One-cycle erase suspend |
| resume_start | output | 1 | One-cycle erase resume |

## Verification
The command decoder is driven with complete correct sequences for program, autoselect, sector erase and chip erase. The same sequences are also driven broken at a single cycle: a wrong address bit, a command byte arriving without its unlocks, and F0h inserted midway. This separates a decoder that compares both address and data from one that checks only data, and one that remembers partial progress from one that restarts. Writes are also issued while busy and while suspended, which shows whether the busy and suspend states filter commands correctly. Read addresses just inside and just outside the suspended sector, together with coincident done and error inputs, exercise the status-select boundary and the completion priority.

// File: rtl/flash_cmd_pkg.sv
package flash_cmd_pkg;

  localparam int KEY_AW = 11;
  localparam logic [KEY_AW-1:0] KEY_A1 = 11'h555;
  localparam logic [KEY_AW-1:0] KEY_A2 = 11'h2AA;

  typedef enum logic [2:0] {
    MD_READ = 3'd0, MD_AUTO = 3'd1, MD_PPEND = 3'd2, MD_EPEND = 3'd3,
    MD_BUSY = 3'd4, MD_SUSP = 3'd5, MD_ERR = 3'd6
  } mode_e;

  typedef enum logic [3:0] {
    S_READ, S_UNL1, S_UNL2, S_AUTO, S_PPEND, S_EUNL0, S_EUNL1, S_EUNL2,
    S_PBUSY, S_EBUSY, S_SUSP, S_SUNL1, S_SUNL2, S_SPPEND, S_SPBUSY, S_ERR
  } st_e;

  typedef struct packed {
    logic unl1;
    logic unl2;
    logic prog;
    logic asel;
    logic esetup;
    logic sect;
    logic chip;
    logic rst;
    logic susp;
    logic resume;
  } cmd_t;

  function automatic cmd_t classify(logic [KEY_AW-1:0] a, logic [7:0] d);
    cmd_t c;
    c.unl1   = (a == KEY_A1) && (d == 8'hAA);
    c.unl2   = (a == KEY_A2) && (d == 8'h55);
    c.prog   = (a == KEY_A1) && (d == 8'hA0);
    c.asel   = (a == KEY_A1) && (d == 8'h90);
    c.esetup = (a == KEY_A1) && (d == 8'h80);
    c.sect   = (d == 8'h30);
    c.chip   = (a == KEY_A1) && (d == 8'h10);
    c.rst    = (d == 8'hF0);
    c.susp   = (d == 8'hB0);
    c.resume = (d == 8'h30);
    return c;
  endfunction

  function automatic mode_e mode_of(st_e s);
    case (s)
      S_AUTO:                    return MD_AUTO;
      S_PPEND, S_SPPEND:         return MD_PPEND;
      S_EUNL0, S_EUNL1, S_EUNL2: return MD_EPEND;
      S_PBUSY, S_EBUSY, S_SPBUSY: return MD_BUSY;
      S_SUSP, S_SUNL1, S_SUNL2:  return MD_SUSP;
      S_ERR:                     return MD_ERR;
      default:                   return MD_READ;
    endcase
  endfunction

  function automatic logic erase_parked(st_e s);
    return (s == S_SUSP) || (s == S_SUNL1) || (s == S_SUNL2) || (s == S_SPPEND);
  endfunction

endpackage

// File: rtl/fcs_decode.sv
module fcs_decode
  import flash_cmd_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic [KEY_AW-1:0] key_addr,
  input  logic [DW-1:0]     wr_data,
  output cmd_t              cmd
);
  always_comb cmd = classify(key_addr, wr_data[7:0]);

  if (DW > 8) begin : g_wide
    logic upper_unused;
    assign upper_unused = |wr_data[DW-1:8];
  end
endmodule

// File: rtl/fcs_seq.sv
module fcs_seq
  import flash_cmd_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wr_valid,
  input  cmd_t cmd,
  input  logic op_done,
  input  logic op_error,
  output st_e  st,
  output logic ev_prog,
  output logic ev_erase,
  output logic ev_chip,
  output logic ev_susp,
  output logic ev_resume
);
  st_e  nxt;
  logic w;
  assign w = wr_valid;

  always_comb begin
    nxt = st;
    ev_prog = 1'b0; ev_erase = 1'b0; ev_chip = 1'b0;
    ev_susp = 1'b0; ev_resume = 1'b0;
    case (st)
      S_READ:  if (w && cmd.unl1) nxt = S_UNL1;
      S_UNL1:  if (w) nxt = cmd.unl2 ? S_UNL2 : S_READ;
      S_UNL2:  if (w) nxt = cmd.prog ? S_PPEND : cmd.asel ? S_AUTO :
                           cmd.esetup ? S_EUNL0 : S_READ;
      S_AUTO:  if (w && cmd.rst) nxt = S_READ;
      S_PPEND: if (w) begin nxt = S_PBUSY; ev_prog = 1'b1; end
      S_EUNL0: if (w) nxt = cmd.unl1 ? S_EUNL1 : S_READ;
      S_EUNL1: if (w) nxt = cmd.unl2 ? S_EUNL2 : S_READ;
      S_EUNL2: if (w) begin
        if (cmd.sect) begin nxt = S_EBUSY; ev_erase = 1'b1; end
        else if (cmd.chip) begin nxt = S_EBUSY; ev_erase = 1'b1; ev_chip = 1'b1; end
        else nxt = S_READ;
      end
      S_PBUSY: if (op_error) nxt = S_ERR; else if (op_done) nxt = S_READ;
      S_EBUSY: begin
        if (op_error) nxt = S_ERR;
        else if (op_done) nxt = S_READ;
        else if (w && cmd.susp) begin nxt = S_SUSP; ev_susp = 1'b1; end
      end
      S_SUSP: if (w) begin
        if (cmd.resume) begin nxt = S_EBUSY; ev_resume = 1'b1; end
        else if (cmd.unl1) nxt = S_SUNL1;
      end
      S_SUNL1:  if (w) nxt = cmd.unl2 ? S_SUNL2 : S_SUSP;
      S_SUNL2:  if (w) nxt = cmd.prog ? S_SPPEND : S_SUSP;
      S_SPPEND: if (w) begin nxt = S_SPBUSY; ev_prog = 1'b1; end
      S_SPBUSY: if (op_error) nxt = S_ERR; else if (op_done) nxt = S_SUSP;
      S_ERR:    if (w && cmd.rst) nxt = S_READ;
      default:  nxt = S_READ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st <= S_READ;
    else        st <= nxt;
  end

  p_err_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_ERR && !(wr_valid && cmd.rst)) |=> st == S_ERR);
  p_busy_ignore_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PBUSY && !op_done && !op_error) |=> st == S_PBUSY);
  p_done_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_PBUSY && op_done && !op_error) |=> st == S_READ);
  p_abort_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_EUNL0 || st == S_EUNL1 || st == S_EUNL2) && wr_valid && cmd.rst)
    |=> st == S_READ);
  p_nested_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_SPBUSY && op_done && !op_error) |=> st == S_SUSP);
endmodule

// File: rtl/fcs_oplatch.sv
module fcs_oplatch #(
  parameter int AW = 20,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ev_prog,
  input  logic          ev_erase,
  input  logic          ev_chip,
  input  logic          ev_susp,
  input  logic          ev_resume,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic          prog_start,
  output logic          erase_start,
  output logic          suspend_start,
  output logic          resume_start,
  output logic [AW-1:0] prog_addr,
  output logic [DW-1:0] prog_data,
  output logic [AW-1:0] erase_addr,
  output logic          erase_chip
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prog_start <= 1'b0; erase_start <= 1'b0;
      suspend_start <= 1'b0; resume_start <= 1'b0;
      prog_addr <= '0; prog_data <= '0; erase_addr <= '0; erase_chip <= 1'b0;
    end else begin
      prog_start    <= ev_prog;
      erase_start   <= ev_erase;
      suspend_start <= ev_susp;
      resume_start  <= ev_resume;
      if (ev_prog) begin
        prog_addr <= wr_addr;
        prog_data <= wr_data;
      end
      if (ev_erase) begin
        erase_addr <= wr_addr;
        erase_chip <= ev_chip;
      end
    end
  end

  p_one_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({prog_start, erase_start, suspend_start, resume_start}));
  p_prog_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
    prog_start |=> !prog_start);
  p_erase_single_r5: assert property (@(posedge clk) disable iff (!rst_n)
    erase_start |=> !erase_start);
endmodule

// File: rtl/fcs_rdstat.sv
module fcs_rdstat
  import flash_cmd_pkg::*;
#(
  parameter int AW = 20,
  parameter int SECT_SHIFT = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  mode_e         mode,
  input  logic          parked,
  input  logic          erase_chip,
  input  logic [AW-1:0] erase_addr,
  input  logic [AW-1:0] rd_addr,
  output logic          rd_status
);
  logic same_sector;
  assign same_sector = (rd_addr >> SECT_SHIFT) == (erase_addr >> SECT_SHIFT);

  always_comb begin
    rd_status = (mode == MD_BUSY) || (mode == MD_ERR) ||
                (parked && (erase_chip || same_sector));
  end

  p_busy_status_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_BUSY || mode == MD_ERR) |-> rd_status);
  p_read_clean_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == MD_READ || mode == MD_AUTO || mode == MD_EPEND) && !parked |-> !rd_status);
endmodule

// File: rtl/flash_cmd_fsm.sv
module flash_cmd_fsm
  import flash_cmd_pkg::*;
#(
  parameter int AW = 20,
  parameter int DW = 8,
  parameter int SECT_SHIFT = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic          op_done,
  input  logic          op_error,
  input  logic [AW-1:0] rd_addr,
  output logic [2:0]    mode,
  output logic          rd_status,
  output logic          prog_start,
  output logic [AW-1:0] prog_addr,
  output logic [DW-1:0] prog_data,
  output logic          erase_start,
  output logic          erase_chip,
  output logic [AW-1:0] erase_addr,
  output logic          suspend_start,
  output logic          resume_start
);
  cmd_t  cmd;
  st_e   st;
  mode_e mode_w;
  logic  parked;
  logic  ev_prog, ev_erase, ev_chip, ev_susp, ev_resume;

  fcs_decode #(.DW(DW)) u_dec (
    .key_addr(wr_addr[KEY_AW-1:0]), .wr_data(wr_data), .cmd(cmd));

  fcs_seq u_seq (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .cmd(cmd),
    .op_done(op_done), .op_error(op_error), .st(st),
    .ev_prog(ev_prog), .ev_erase(ev_erase), .ev_chip(ev_chip),
    .ev_susp(ev_susp), .ev_resume(ev_resume));

  fcs_oplatch #(.AW(AW), .DW(DW)) u_lat (
    .clk(clk), .rst_n(rst_n), .ev_prog(ev_prog), .ev_erase(ev_erase),
    .ev_chip(ev_chip), .ev_susp(ev_susp), .ev_resume(ev_resume),
    .wr_addr(wr_addr), .wr_data(wr_data),
    .prog_start(prog_start), .erase_start(erase_start),
    .suspend_start(suspend_start), .resume_start(resume_start),
    .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_addr(erase_addr), .erase_chip(erase_chip));

  assign mode_w = mode_of(st);
  assign parked = erase_parked(st);
  assign mode   = mode_w;

  fcs_rdstat #(.AW(AW), .SECT_SHIFT(SECT_SHIFT)) u_rs (
    .clk(clk), .rst_n(rst_n), .mode(mode_w), .parked(parked),
    .erase_chip(erase_chip), .erase_addr(erase_addr),
    .rd_addr(rd_addr), .rd_status(rd_status));

  p_reset_mode_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> mode == 3'd0);
endmodule

// File: tb/tb_flash_cmd_fsm.sv
module tb_flash_cmd_fsm;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 20;
  localparam int DW = 8;
  localparam int NV = 46;

  // vector: {valid, addr[19:0], data[7:0], done, err, exp_mode[2:0], exp_pulse[3:0]}
  // exp_pulse order {prog, erase, suspend, resume}
  localparam logic [37:0] VEC [NV] = '{
    {1'b1,20'h00555,8'hAA,1'b0,1'b0,3'd0,4'b0000},   // 0  R2
    {1'b1,20'h002AA,8'h55,1'b0,1'b0,3'd0,4'b0000},
    {1'b1,20'h00555,8'hA0,1'b0,1'b0,3'd2,4'b0000},
    {1'b1,20'h12345,8'h3C,1'b0,1'b0,3'd4,4'b1000},
    {1'b0,20'h00000,8'h00,1'b0,1'b0,3'd4,4'b0000},
    {1'b1,20'h00555,8'hAA,1'b0,1'b0,3'd4,4'b0000},   // 5  R6
    {1'b1,20'h00000,8'hB0,1'b0,1'b0,3'd4,4'b0000},   //    R6
    {1'b0,20'h00000,8'h00,1'b1,1'b0,3'd0,4'b0000},   //    R9
    {1'b1,20'h00555,8'hAA,1'b0,1'b0,3'd0,4'b0000},   //    R3
    {1'b1,20'h002AB,8'h55,1'b0,1'b0,3'd0,4'b0000},
    {1'b1,20'h00555,8'hA0,1'b0,1'b0,3'd0,4'b0000},   // 10
    {1'b1,20'h00555,8'hAA,1'b0,1'b0,3'd0,4'b0000},
    {1'b1,20'h002AA,8'h55,1'b0,1'b0,3'd0,4'b0000},
    {1'b1,20'h00555,8'h90,1'b0,1'b0,3'd1,4'b0000},
    {1'b1,20'h00555,8'hAA,1'b0,1'b0,3'd1,4'b0000},
    {1'b1,20'hABCDE,8'hF0,1'b0,1'b0,3'd0,4'b0000},   // 15 R4
    {1'b1,20'h00555,8'hAA,1'b0,1'b0,3'd0,4'b0000},
    {1'b1,20'h002AA,8'h55,1'b0,1'b0,3'd0,4'b0000},
    {1'b1,20'h00555,8'h80,1'b0,1'b0,3'd3,4'b0000},
    {1'b1,20'h00555,8'hAA,1'b0,1'b0,3'd3,4'b0000},
    {1'b1,20'h7FFFF,8'hF0,1'b0,1'b0,3'd0,4'b0000},   // 20 R4
    {1'b1,20'h00555,8'hAA,1'b0,1'b0,3'd0,4'b0000},   //    R5
    {1'b1,20'h002AA,8'h55,1'b0,1'b0,3'd0,4'b0000},
    {1'b1,20'h00555,8'h80,1'b0,1'b0,3'd3,4'b0000},
    {1'b1,20'h00555,8'hAA,1'b0,1'b0,3'd3,4'b0000},
    {1'b1,20'h002AA,8'h55,1'b0,1'b0,3'd3,4'b0000},   // 25
    {1'b1,20'h24000,8'h30,1'b0,1'b0,3'd4,4'b0100},
    {1'b1,20'h00000,8'hB0,1'b0,1'b0,3'd5,4'b0010},   //    R7
    {1'b1,20'h00555,8'hAA,1'b0,1'b0,3'd5,4'b0000},   //    R8
    {1'b1,20'h002AA,8'h55,1'b0,1'b0,3'd5,4'b0000},
    {1'b1,20'h00555,8'hA0,1'b0,1'b0,3'd2,4'b0000},   // 30
    {1'b1,20'h01000,8'h5A,1'b0,1'b0,3'd4,4'b1000},
    {1'b0,20'h00000,8'h00,1'b1,1'b0,3'd5,4'b0000},
    {1'b1,20'h00123,8'h77,1'b0,1'b0,3'd5,4'b0000},   //    R11
    {1'b1,20'h00000,8'h30,1'b0,1'b0,3'd4,4'b0001},   //    R7
    {1'b0,20'h00000,8'h00,1'b0,1'b1,3'd6,4'b0000},   // 35 R9
    {1'b1,20'h00555,8'hAA,1'b0,1'b0,3'd6,4'b0000},
    {1'b1,20'h00000,8'hF0,1'b0,1'b0,3'd0,4'b0000},
    {1'b1,20'h00555,8'hAA,1'b0,1'b0,3'd0,4'b0000},   //    R5 chip
    {1'b1,20'h002AA,8'h55,1'b0,1'b0,3'd0,4'b0000},
    {1'b1,20'h00555,8'h80,1'b0,1'b0,3'd3,4'b0000},   // 40
    {1'b1,20'h00555,8'hAA,1'b0,1'b0,3'd3,4'b0000},
    {1'b1,20'h002AA,8'h55,1'b0,1'b0,3'd3,4'b0000},
    {1'b1,20'h00555,8'h10,1'b0,1'b0,3'd4,4'b0100},
    {1'b0,20'h00000,8'h00,1'b1,1'b0,3'd0,4'b0000},
    {1'b0,20'h00000,8'h00,1'b1,1'b0,3'd0,4'b0000}    // 45 R9
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          op_done = 1'b0;
  logic          op_error = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [2:0]    mode;
  logic          rd_status, prog_start, erase_start, erase_chip;
  logic          suspend_start, resume_start;
  logic [AW-1:0] prog_addr, erase_addr;
  logic [DW-1:0] prog_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  flash_cmd_fsm #(.AW(AW), .DW(DW), .SECT_SHIFT(12)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .op_done(op_done), .op_error(op_error),
    .rd_addr(rd_addr), .mode(mode), .rd_status(rd_status),
    .prog_start(prog_start), .prog_addr(prog_addr), .prog_data(prog_data),
    .erase_start(erase_start), .erase_chip(erase_chip),
    .erase_addr(erase_addr), .suspend_start(suspend_start),
    .resume_start(resume_start));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // called at a negedge; applies one cycle of inputs and returns at the next negedge
  task automatic step(input logic v, input logic [AW-1:0] a, input logic [DW-1:0] d,
                      input logic dn, input logic er);
    wr_valid = v; wr_addr = a; wr_data = d; op_done = dn; op_error = er;
    @(posedge clk);
    @(negedge clk);
    wr_valid = 1'b0; op_done = 1'b0; op_error = 1'b0;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    step(1'b1, a, d, 1'b0, 1'b0);
  endtask

  function automatic logic [3:0] pulses();
    return {prog_start, erase_start, suspend_start, resume_start};
  endfunction

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset mode", 32'(mode), 32'd0);
    chk("R1 reset pulses", 32'(pulses()), 32'd0);
    chk("R1 reset rd_status", 32'(rd_status), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 mode after release", 32'(mode), 32'd0);

    for (int i = 0; i < NV; i++) begin
      logic [37:0] v;
      v = VEC[i];
      step(v[37], v[36:17], v[16:9], v[8], v[7]);
      chk($sformatf("R2-table step %0d mode", i), 32'(mode), 32'(v[6:4]));
      chk($sformatf("R5-table step %0d pulses", i), 32'(pulses()), 32'(v[3:0]));
    end

    // R2: program address/data and R10 busy status, R9 coincident done+error
    wr(20'h00555, 8'hAA); wr(20'h002AA, 8'h55); wr(20'h00555, 8'hA0);
    wr(20'hABCDE, 8'h5A);
    chk("R2 prog_start", 32'(prog_start), 32'd1);
    chk("R2 prog_addr", 32'(prog_addr), 32'hABCDE);
    chk("R2 prog_data", 32'(prog_data), 32'h5A);
    chk("R10 busy status", 32'(rd_status), 32'd1);
    step(1'b0, '0, '0, 1'b1, 1'b1);
    chk("R9 error beats done", 32'(mode), 32'd6);
    chk("R10 error status", 32'(rd_status), 32'd1);
    wr(20'h00000, 8'hF0);
    chk("R9 F0 leaves error", 32'(mode), 32'd0);

    // R5 sector erase, R10 sector window, R11 F0 in suspend
    wr(20'h00555, 8'hAA); wr(20'h002AA, 8'h55); wr(20'h00555, 8'h80);
    wr(20'h00555, 8'hAA); wr(20'h002AA, 8'h55); wr(20'h24000, 8'h30);
    chk("R5 erase_addr", 32'(erase_addr), 32'h24000);
    chk("R5 erase_chip sector", 32'(erase_chip), 32'd0);
    wr(20'h00000, 8'hB0);
    rd_addr = 20'h24FFF; #1;
    chk("R10 inside suspended sector", 32'(rd_status), 32'd1);
    rd_addr = 20'h25000; #1;
    chk("R10 outside suspended sector", 32'(rd_status), 32'd0);
    rd_addr = 20'h23FFF; #1;
    chk("R10 below suspended sector", 32'(rd_status), 32'd0);
    wr(20'h00000, 8'hF0);
    chk("R11 F0 ignored in suspend", 32'(mode), 32'd5);
    wr(20'h00555, 8'hAA); wr(20'h002AB, 8'h55);
    chk("R11 bad unlock stays suspended", 32'(mode), 32'd5);
    wr(20'h00000, 8'h30);
    chk("R7 resume mode", 32'(mode), 32'd4);
    step(1'b0, '0, '0, 1'b1, 1'b0);
    chk("R9 erase done", 32'(mode), 32'd0);
    rd_addr = 20'h24000; #1;
    chk("R10 read mode no status", 32'(rd_status), 32'd0);

    // R5 chip erase flag, R10 chip suspend, R1 reset mid-operation
    wr(20'h00555, 8'hAA); wr(20'h002AA, 8'h55); wr(20'h00555, 8'h80);
    wr(20'h00555, 8'hAA); wr(20'h002AA, 8'h55); wr(20'h00555, 8'h10);
    chk("R5 erase_chip", 32'(erase_chip), 32'd1);
    wr(20'h00000, 8'hB0);
    rd_addr = 20'hFF000; #1;
    chk("R10 chip suspend any address", 32'(rd_status), 32'd1);
    rst_n = 1'b0; #1;
    chk("R1 async reset mode", 32'(mode), 32'd0);
    chk("R1 async reset status", 32'(rd_status), 32'd0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", 32'(mode), 32'd0);

    finish_run();
  end
endmodule